// File: doc/BRIEF.md
# Serial/Nibble Payload Intake

This block takes outbound frame payload from system-side equipment and hands it to a downstream framer as a serial bit stream with a per-bit valid flag. A static mode input picks one of two intake styles. In bit mode, one payload bit is sampled on every rising edge of the active timing clock. In nibble mode, the block drives a nibble clock at one quarter of the active clock rate. It captures a 4-bit nibble at a fixed phase of that clock and shifts the nibble out most significant bit first. During the last nibble of every frame it raises an end-of-frame strobe, so the system knows to start sending the next frame.

The active timing clock is chosen by configuration. It is either a local transmit clock or a recovered receive clock, the latter for loop timing. The frame length in payload bits is a parameter.

Top module: `payload_intake`

## Requirements
- R1: `nib_mode` low selects bit mode and high selects nibble mode. `nib_din` has no effect in bit mode, and `ser_din` has no effect in nibble mode.
- R2: In bit mode, after each active rising edge `pay_bit_o` equals the `ser_din` value sampled at that edge, and `pay_vld_o` is high.
- R3: `loop_sel` low makes `clk_local` the active clock, and `loop_sel` high makes `clk_recov` the active clock. The other clock has no effect.
- R4: In nibble mode, `nib_clk_o` repeats with a period of four active cycles: high for two cycles, then low for two.
- R5: A nibble is captured on the third active rising edge after each rising edge of `nib_clk_o`. After reset is released, `nib_clk_o` first goes high after the 2nd active edge, and the first payload bit appears after the 5th active edge.
- R6: A captured nibble leaves on `pay_bit_o` as bit 3, then bit 2, bit 1 and bit 0. The four bits appear on four consecutive active cycles, starting in the cycle after the capture edge, with `pay_vld_o` high. Nibbles follow back to back with no gap.
- R7: `eof_o` is high for exactly the four cycles that carry the bits of nibble index FRAME_BITS/4-1 of each frame, and low otherwise. Nibble indices count from 0 and wrap at FRAME_BITS/4.
- R8: In bit mode, `nib_clk_o` and `eof_o` stay low.
- R9: While `rst` is high at an active edge, `nib_clk_o`, `eof_o` and `pay_vld_o` go low. The first nibble captured after reset is nibble 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_local | input | 1 | Local transmit timing clock |
| clk_recov | input | 1 | Recovered receive clock, used for loop timing |
| loop_sel | input | 1 | Clock source select: 1 selects clk_recov, 0 selects clk_local |
| rst | input | 1 | Synchronous active-high reset |
| nib_mode | input | 1 | Intake style: 1 selects nibble mode, 0 selects bit mode |
| ser_din | input | 1 | Serial payload bit (bit mode) |
| nib_din | input | 4 | Parallel payload nibble (nibble mode) |
| nib_clk_o | output | 1 | Nibble clock, one quarter of the active clock rate |
| eof_o | output | 1 | Strobe during the last nibble of each frame |
| pay_bit_o | output | 1 | Serialized payload bit to the framer |
| pay_vld_o | output | 1 | Payload bit valid |

## Verification
Nibble mode is driven with sixteen nibbles of distinct values covering two short frames. The system-side update is applied on each observed nibble clock rise, and `ser_din` toggles at the same time. Matching the bit order shows MSB-first shifting and that the serial input is ignored. The exact cycle of the first valid bit separates the third-edge capture from the other phases, and the position of the strobe catches an off-by-one in the frame count. Bit mode is driven with an irregular bit pattern while `nib_din` churns, once on the local clock and once on the recovered clock with the local clock stopped. These runs separate the clock selection and confirm that the nibble outputs stay quiet.

// File: rtl/payload_intake_pkg.sv
package payload_intake_pkg;

    typedef logic [1:0] phase_t;

    typedef struct packed {
        phase_t ph;
        logic   primed;
    } tmr_regs_t;

    typedef struct packed {
        logic       bit_v;
        logic       vld;
        logic [2:0] sh;
        logic [1:0] left;
    } shf_regs_t;

endpackage

// File: rtl/pi_nib_timer.sv
module pi_nib_timer
    import payload_intake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nib_mode,
    output logic nib_clk,
    output logic cap
);
    tmr_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (rst || !nib_mode) begin
            r_d.ph     = '0;
            r_d.primed = 1'b0;
        end else begin
            r_d.ph = r_q.ph + 2'd1;
            if (r_q.ph == 2'd1) r_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign nib_clk = nib_mode & r_q.ph[1];
    assign cap     = nib_mode & r_q.primed & (r_q.ph == 2'd0);

    AST_CAP_PHASE: assert property (@(posedge clk) disable iff (rst)
        cap |-> (!nib_clk && $past(nib_clk)));  // R5

    AST_NCLK_HOLD: assert property (@(posedge clk) disable iff (rst || !nib_mode)
        $rose(nib_clk) |=> nib_clk);  // R4

endmodule

// File: rtl/pi_frame_cnt.sv
module pi_frame_cnt #(
    parameter int FRAME_BITS = 4704
) (
    input  logic clk,
    input  logic rst,
    input  logic nib_mode,
    input  logic cap,
    output logic eof
);
    localparam int FRAME_NIB = FRAME_BITS / 4;
    localparam int CW        = (FRAME_NIB > 1) ? $clog2(FRAME_NIB) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_NIB - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          eof;
    } frm_regs_t;

    frm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (rst || !nib_mode) begin
            r_d.cnt = '0;
            r_d.eof = 1'b0;
        end else if (cap) begin
            r_d.eof = (r_q.cnt == LAST);
            r_d.cnt = (r_q.cnt == LAST) ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign eof = r_q.eof;

    AST_EOF_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.eof) |-> (r_q.cnt == '0));  // R7

endmodule

// File: rtl/pi_shifter.sv
module pi_shifter
    import payload_intake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       nib_mode,
    input  logic       cap,
    input  logic [3:0] nib_din,
    input  logic       ser_din,
    output logic       pay_bit,
    output logic       pay_vld
);
    shf_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d = '0;
        end else if (!nib_mode) begin
            r_d.bit_v = ser_din;
            r_d.vld   = 1'b1;
            r_d.sh    = '0;
            r_d.left  = '0;
        end else if (cap) begin
            r_d.bit_v = nib_din[3];
            r_d.sh    = nib_din[2:0];
            r_d.left  = 2'd3;
            r_d.vld   = 1'b1;
        end else if (r_q.left != 2'd0) begin
            r_d.bit_v = r_q.sh[2];
            r_d.sh    = {r_q.sh[1:0], 1'b0};
            r_d.left  = r_q.left - 2'd1;
            r_d.vld   = 1'b1;
        end else begin
            r_d.bit_v = 1'b0;
            r_d.vld   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign pay_bit = r_q.bit_v;
    assign pay_vld = r_q.vld;

    AST_SERIAL_PASS: assert property (@(posedge clk) disable iff (rst)
        (!nib_mode && !$past(nib_mode) && !$past(rst)) |-> (r_q.bit_v == $past(ser_din) && r_q.vld));  // R2

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (cap && r_q.vld && nib_mode) |-> (r_q.left == 2'd0));  // R6

endmodule

// File: rtl/payload_intake.sv
module payload_intake #(
    parameter int FRAME_BITS = 4704
) (
    input  logic       clk_local,
    input  logic       clk_recov,
    input  logic       loop_sel,
    input  logic       rst,
    input  logic       nib_mode,
    input  logic       ser_din,
    input  logic [3:0] nib_din,
    output logic       nib_clk_o,
    output logic       eof_o,
    output logic       pay_bit_o,
    output logic       pay_vld_o
);
    logic act_clk;
    logic cap;

    assign act_clk = loop_sel ? clk_recov : clk_local;

    pi_nib_timer u_tmr (
        .clk      (act_clk),
        .rst      (rst),
        .nib_mode (nib_mode),
        .nib_clk  (nib_clk_o),
        .cap      (cap)
    );

    pi_frame_cnt #(.FRAME_BITS(FRAME_BITS)) u_frm (
        .clk      (act_clk),
        .rst      (rst),
        .nib_mode (nib_mode),
        .cap      (cap),
        .eof      (eof_o)
    );

    pi_shifter u_shf (
        .clk      (act_clk),
        .rst      (rst),
        .nib_mode (nib_mode),
        .cap      (cap),
        .nib_din  (nib_din),
        .ser_din  (ser_din),
        .pay_bit  (pay_bit_o),
        .pay_vld  (pay_vld_o)
    );

    AST_SER_QUIET: assert property (@(posedge act_clk) disable iff (rst)
        !nib_mode |-> (!eof_o && !nib_clk_o));  // R8

endmodule

// File: tb/payload_intake_bench.sv
module payload_intake_bench;
    localparam int FB   = 32;
    localparam int FNIB = FB / 4;
    localparam int NTBL = 16;
    localparam logic [3:0] NIB_TBL [NTBL] = '{
        4'hA, 4'h3, 4'hF, 4'h0, 4'h5, 4'hC, 4'h9, 4'h6,
        4'h1, 4'h8, 4'hE, 4'h7, 4'h2, 4'hB, 4'h4, 4'hD };

    logic clk_local = 0, clk_recov = 0;
    logic loc_en = 1, rec_en = 1;
    logic loop_sel = 0, rst = 1, nib_mode = 1, ser_din = 0;
    logic [3:0] nib_din = 0;
    logic nib_clk_o, eof_o, pay_bit_o, pay_vld_o;
    logic act_clk;
    int errors = 0, checks = 0;

    assign act_clk = loop_sel ? clk_recov : clk_local;

    always begin #5; if (loc_en) clk_local = ~clk_local; end
    always begin #7; if (rec_en) clk_recov = ~clk_recov; end

    payload_intake #(.FRAME_BITS(FB)) u_payload_intake (
        .clk_local(clk_local), .clk_recov(clk_recov), .loop_sel(loop_sel),
        .rst(rst), .nib_mode(nib_mode), .ser_din(ser_din), .nib_din(nib_din),
        .nib_clk_o(nib_clk_o), .eof_o(eof_o), .pay_bit_o(pay_bit_o), .pay_vld_o(pay_vld_o));

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge act_clk);
        chk("R9", nib_clk_o, 1'b0, "nib_clk in reset");
        chk("R9", eof_o, 1'b0, "eof in reset");
        chk("R9", pay_vld_o, 1'b0, "valid in reset");
        rst = 0;
    endtask

    task automatic serial_run(input string req, input logic [19:0] pat);
        logic prev;
        prev = 1'b0;
        for (int i = 0; i <= 20; i++) begin
            @(negedge act_clk);
            if (i > 0) begin
                chk(req, pay_bit_o, prev, "serial bit");
                chk(req, pay_vld_o, 1'b1, "serial valid");
                chk("R8", nib_clk_o, 1'b0, "nib_clk in bit mode");
                chk("R8", eof_o, 1'b0, "eof in bit mode");
            end
            if (i < 20) begin
                ser_din = pat[i];
                prev    = pat[i];
                nib_din = 4'(i * 7 + 3);  // R1: ignored in bit mode
            end
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bidx, tidx, first_n;
        logic prev_nclk, eb;
        // nibble mode, local clock
        nib_mode = 1; loop_sel = 0;
        do_reset();
        bidx = 0; tidx = 0; first_n = -1; prev_nclk = 0;
        for (int n = 1; n <= 72; n++) begin
            @(negedge act_clk);
            if (n <= 12) chk("R4", nib_clk_o, ((n % 4) >= 2) ? 1'b1 : 1'b0, "nib_clk pattern");
            if (pay_vld_o && first_n < 0) begin
                first_n = n;
                checks++;
                if (n != 5) begin
                    errors++;
                    $display("FAIL R5 first valid cycle: actual=%0d expected=5", n);
                end
            end
            if (bidx < NTBL * 4) begin
                if (pay_vld_o) begin
                    eb = NIB_TBL[bidx / 4][3 - (bidx % 4)];
                    chk("R6", pay_bit_o, eb, "nibble bit order");
                    chk("R7", eof_o, (((bidx / 4) % FNIB) == FNIB - 1) ? 1'b1 : 1'b0, "eof position");
                    bidx++;
                end else begin
                    chk("R7", eof_o, 1'b0, "eof while idle");
                    if (bidx > 0) chk("R6", pay_vld_o, 1'b1, "valid gap");
                end
            end
            if (nib_clk_o && !prev_nclk && tidx < NTBL) begin
                nib_din = NIB_TBL[tidx];
                tidx++;
            end
            ser_din = ~ser_din;  // R1: ignored in nibble mode
            prev_nclk = nib_clk_o;
        end
        checks++;
        if (bidx != NTBL * 4) begin
            errors++;
            $display("FAIL R9 bits delivered: actual=%0d expected=%0d", bidx, NTBL * 4);
        end

        // bit mode, local clock
        nib_mode = 0;
        do_reset();
        serial_run("R2", 20'b1011_0011_1000_1110_0101);

        // bit mode, recovered clock, local clock stopped
        loop_sel = 1;
        loc_en = 0;
        do_reset();
        serial_run("R3", 20'b0100_1101_0111_0001_1010);
        loc_en = 1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule